// File: doc/BRIEF.md
# Tone Burst Sequencer

This block is the digital half of a tone generator. Running from a tone master clock, it produces a step strobe at 128 times a programmed frequency, walks a 128-entry sine table (or produces a two-level square wave) and presents a signed sample on each step. Tones are played as bursts whose length is counted in tenths of a second. A new tone written while a burst is playing is held back and follows on without a phase jump.

A burst never stops mid-waveform. Once its time is up, the burst runs on to the next stop point. Depending on a finish-mode input, that point is either the next zero crossing or the next whole-cycle boundary. An optional pattern mode plays one cycle at the set frequency and then two cycles at double the frequency, and repeats this. The busy output tells software that a follow-on tone is waiting.

The inputs are register values and single-cycle write strobes for frequency and duration. The outputs are the sample, the step strobe and busy.

Top module: `tone_burst_seq`

## Requirements
- R1: While a burst runs, a phase accumulator adds 128·F (256·F in double-rate parts of the pattern) on every clock, modulo REF_CLK. The table index advances by exactly one, modulo 128, on each wrap, and `step_stb` pulses high for one cycle in the clock after each such edge. 128·F must stay below REF_CLK/2.
- R2: In sine mode, the sample for index k is round(A·sin(2πk/128)), rounded half away from zero, where A = 2^(SAMP_W-1) − 1.
- R3: In square mode, the sample is +A for indices 0 to 63 and −A for indices 64 to 127.
- R4: A burst starts only when both the held frequency and the held duration are non-zero, after a write to either of them. Writing a frequency alone while the duration is 0 starts nothing. Writing a non-zero duration while a frequency is held restarts the tone at that frequency, from index 0.
- R5: A frequency or non-zero duration write during a burst is queued, and `busy` goes high on the next clock. The field that was not written carries over from the current burst. At the stop point the queued tone continues from the current index and accumulator without a restart, and `busy` drops.
- R6: With `fin_zero`=1 a burst ends on the first step landing on index 0 or 64 after its time expires. With `fin_zero`=0 it ends only on a step landing on index 0.
- R7: One duration unit lasts REF_CLK/10 clocks. Writing duration 0 during a burst drops any queued tone and ends the burst at the next stop point given by R6.
- R8: When a burst ends with nothing queued, the held duration becomes 0 and the frequency is kept. A later frequency write alone does not restart, but a later duration write does.
- R9: With `f2f_mode`=1 the burst repeats one cycle at F followed by two cycles at 2F, with cycles counted at index-0 steps.
- R10: After reset, and whenever no burst runs, `sample`=0, `busy`=0 and `step_stb`=0. The step that ends a burst still pulses `step_stb` and shows `sample`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tone master clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_val | input | FREQ_W | Frequency value, 1 Hz units at nominal clock, 0 = off |
| freq_wr | input | 1 | One-cycle write strobe for `freq_val` |
| dur_val | input | DUR_W | Duration in 0.1 s units, 0 = stop |
| dur_wr | input | 1 | One-cycle write strobe for `dur_val` |
| square_mode | input | 1 | 1 = square wave, 0 = sine |
| fin_zero | input | 1 | 1 = end at zero crossing, 0 = end at whole cycle |
| f2f_mode | input | 1 | 1 = one cycle at F then two at 2F |
| sample | output | SAMP_W | Signed output sample |
| step_stb | output | 1 | Pulses once per table step |
| busy | output | 1 | A queued tone is pending |

## Verification
The bench predicts the exact number of steps in each burst, and the sample on each step, from the accumulator rate and the stop rules. Four errors would show up as a different count:
- a design that counted duration one unit late would add a whole cycle;
- one that ignored the finish mode would run 128 steps where 64 are expected;
- one that restarted the phase on chaining, or lost the carried duration, would mis-sequence the follow-on burst;
- a wrong double-rate pattern would give 256 steps instead of 384.

It also checks that a lone frequency write after an ended burst stays silent, and that a zero-duration write drops a queued tone so no chain follows.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int IDX_W = 7;
  localparam int STEPS = 1 << IDX_W;

  function automatic int sine_code(int k, int amp);
    real a;
    a = $sin(2.0 * 3.141592653589793 * k / STEPS) * amp;
    if (a >= 0.0) return $rtoi(a + 0.5);
    return -$rtoi(-a + 0.5);
  endfunction
endpackage

// File: rtl/tone_step_gen.sv
module tone_step_gen #(
  parameter int REF_CLK = 27_000_000,
  parameter int FREQ_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              dbl,
  input  logic [FREQ_W-1:0] freq,
  output logic              tick
);
  localparam int REF_W = $clog2(REF_CLK) + 1;
  localparam int INC_W = FREQ_W + 8;
  localparam int SUM_W = ((REF_W > INC_W) ? REF_W : INC_W) + 1;
  localparam logic [SUM_W-1:0] REF_V = SUM_W'(REF_CLK);

  logic [SUM_W-1:0] acc_q, inc, sum;

  always_comb begin
    inc  = dbl ? (SUM_W'(freq) << 8) : (SUM_W'(freq) << 7);
    sum  = acc_q + inc;
    tick = en && (sum >= REF_V);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) acc_q <= '0;
    else            acc_q <= tick ? (sum - REF_V) : sum;
  end

  p_acc_bound_r1: assert property (@(posedge clk) disable iff (rst)
    en |=> acc_q < REF_V);
endmodule

// File: rtl/tone_wave_rom.sv
module tone_wave_rom
  import tone_pkg::*;
#(
  parameter int SAMP_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic                     zero_out,
  input  logic                     square,
  input  logic [IDX_W-1:0]         idx,
  output logic signed [SAMP_W-1:0] sample
);
  localparam int AMP = (1 << (SAMP_W - 1)) - 1;
  localparam logic signed [SAMP_W-1:0] POS = SAMP_W'(AMP);
  localparam logic signed [SAMP_W-1:0] NEG = -POS;

  logic signed [SAMP_W-1:0] rom [STEPS];

  initial begin
    for (int k = 0; k < STEPS; k++) rom[k] = SAMP_W'(sine_code(k, AMP));
  end

  always_ff @(posedge clk) begin
    if (rst || zero_out) sample <= '0;
    else if (load)       sample <= square ? (idx[IDX_W-1] ? NEG : POS) : rom[idx];
  end

  p_square_level_r3: assert property (@(posedge clk) disable iff (rst)
    (load && !zero_out && square) |=> (sample == POS || sample == NEG));
endmodule

// File: rtl/tone_burst_ctrl.sv
module tone_burst_ctrl
  import tone_pkg::*;
#(
  parameter int REF_CLK = 27_000_000,
  parameter int FREQ_W  = 15,
  parameter int DUR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREQ_W-1:0] freq_val,
  input  logic              freq_wr,
  input  logic [DUR_W-1:0]  dur_val,
  input  logic              dur_wr,
  input  logic              fin_zero,
  input  logic              f2f_mode,
  input  logic              tick,
  output logic              run,
  output logic [FREQ_W-1:0] gen_freq,
  output logic              gen_dbl,
  output logic [IDX_W-1:0]  rom_idx,
  output logic              rom_load,
  output logic              rom_zero,
  output logic              step_stb,
  output logic              busy
);
  localparam int UNIT   = REF_CLK / 10;
  localparam int UCNT_W = $clog2(UNIT);
  localparam logic [UCNT_W-1:0] UNIT_LAST = UCNT_W'(UNIT - 1);
  localparam logic [IDX_W-1:0]  HALF      = IDX_W'(STEPS / 2);

  logic              run_q, pend_q, stop_q, step_q;
  logic [FREQ_W-1:0] freq_q, nxt_freq_q, f_new;
  logic [DUR_W-1:0]  dur_q, nxt_dur_q, d_new;
  logic [UCNT_W-1:0] ucnt_q;
  logic [IDX_W-1:0]  idx_q, idx_nx;
  logic [1:0]        seg_q;
  logic unit_tick, expiring, at_full, at_bound, done, chain, end_burst, start;

  always_comb begin
    f_new     = freq_wr ? freq_val : freq_q;
    d_new     = dur_wr  ? dur_val  : dur_q;
    start     = !run_q && (freq_wr || dur_wr) && (f_new != '0) && (d_new != '0);
    unit_tick = run_q && (ucnt_q == UNIT_LAST);
    expiring  = unit_tick && (dur_q == DUR_W'(1));
    idx_nx    = idx_q + 1'b1;
    at_full   = (idx_nx == '0);
    at_bound  = fin_zero ? (at_full || idx_nx == HALF) : at_full;
    done      = run_q && tick && at_bound && (stop_q || expiring);
    chain     = done && pend_q && (nxt_freq_q != '0) && (nxt_dur_q != '0);
    end_burst = done && !chain;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; pend_q <= 1'b0; stop_q <= 1'b0; step_q <= 1'b0;
      freq_q <= '0; nxt_freq_q <= '0; dur_q <= '0; nxt_dur_q <= '0;
      ucnt_q <= '0; idx_q <= '0; seg_q <= '0;
    end else begin
      step_q <= run_q && tick;
      if (!run_q) begin
        if (freq_wr) freq_q <= freq_val;
        if (dur_wr)  dur_q  <= dur_val;
        if (start) begin
          run_q <= 1'b1; idx_q <= '0; seg_q <= '0; ucnt_q <= '0;
          stop_q <= 1'b0; pend_q <= 1'b0;
          nxt_freq_q <= f_new; nxt_dur_q <= d_new;
        end
      end else begin
        ucnt_q <= unit_tick ? '0 : ucnt_q + 1'b1;
        if (unit_tick && dur_q != '0) dur_q <= dur_q - 1'b1;
        if (expiring) stop_q <= 1'b1;
        if (tick) begin
          idx_q <= idx_nx;
          if (!f2f_mode)    seg_q <= '0;
          else if (at_full) seg_q <= (seg_q == 2'd2) ? 2'd0 : seg_q + 2'd1;
        end
        if (chain) begin
          freq_q <= nxt_freq_q; dur_q <= nxt_dur_q;
          ucnt_q <= '0; stop_q <= 1'b0; pend_q <= 1'b0;
        end
        if (dur_wr && dur_val == '0) begin
          stop_q <= 1'b1; pend_q <= 1'b0; dur_q <= '0;
        end else if (freq_wr || dur_wr) begin
          pend_q <= 1'b1;
          if (freq_wr) nxt_freq_q <= freq_val;
          if (dur_wr)  nxt_dur_q  <= dur_val;
        end
        if (end_burst) begin
          run_q <= 1'b0; dur_q <= '0; stop_q <= 1'b0; pend_q <= 1'b0;
          if (pend_q) freq_q <= nxt_freq_q;
        end
      end
    end
  end

  assign run      = run_q;
  assign gen_freq = freq_q;
  assign gen_dbl  = f2f_mode && (seg_q != 2'd0);
  assign rom_idx  = start ? '0 : idx_nx;
  assign rom_load = start || (run_q && tick);
  assign rom_zero = end_burst;
  assign step_stb = step_q;
  assign busy     = pend_q;

  p_busy_needs_run_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_q);
  p_idx_step_r1: assert property (@(posedge clk) disable iff (rst)
    step_q |-> idx_q == $past(idx_q) + 1'b1);
  p_stop_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> (idx_q == '0 || ($past(fin_zero) && idx_q == HALF)));
  p_dur_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> dur_q == '0);
  p_start_valid_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> (freq_q != '0 && dur_q != '0));
endmodule

// File: rtl/tone_burst_seq.sv
module tone_burst_seq
  import tone_pkg::*;
#(
  parameter int REF_CLK = 27_000_000,
  parameter int FREQ_W  = 15,
  parameter int DUR_W   = 8,
  parameter int SAMP_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [FREQ_W-1:0]        freq_val,
  input  logic                     freq_wr,
  input  logic [DUR_W-1:0]         dur_val,
  input  logic                     dur_wr,
  input  logic                     square_mode,
  input  logic                     fin_zero,
  input  logic                     f2f_mode,
  output logic signed [SAMP_W-1:0] sample,
  output logic                     step_stb,
  output logic                     busy
);
  logic              run, tick, gen_dbl, rom_load, rom_zero;
  logic [FREQ_W-1:0] gen_freq;
  logic [IDX_W-1:0]  rom_idx;

  tone_burst_ctrl #(.REF_CLK(REF_CLK), .FREQ_W(FREQ_W), .DUR_W(DUR_W)) u_ctrl (
    .clk(clk), .rst(rst), .freq_val(freq_val), .freq_wr(freq_wr),
    .dur_val(dur_val), .dur_wr(dur_wr), .fin_zero(fin_zero), .f2f_mode(f2f_mode),
    .tick(tick), .run(run), .gen_freq(gen_freq), .gen_dbl(gen_dbl),
    .rom_idx(rom_idx), .rom_load(rom_load), .rom_zero(rom_zero),
    .step_stb(step_stb), .busy(busy)
  );

  tone_step_gen #(.REF_CLK(REF_CLK), .FREQ_W(FREQ_W)) u_gen (
    .clk(clk), .rst(rst), .en(run), .dbl(gen_dbl), .freq(gen_freq), .tick(tick)
  );

  tone_wave_rom #(.SAMP_W(SAMP_W)) u_rom (
    .clk(clk), .rst(rst), .load(rom_load), .zero_out(rom_zero),
    .square(square_mode), .idx(rom_idx), .sample(sample)
  );

  p_idle_silent_r10: assert property (@(posedge clk) disable iff (rst)
    (!run && !$past(run)) |-> (sample == '0 && !step_stb));
endmodule

// File: tb/test_tone_burst_seq.sv
module test_tone_burst_seq;
  localparam int REF_CLK = 5120;
  localparam int SAMP_W  = 16;
  localparam int AMP     = (1 << (SAMP_W - 1)) - 1;

  logic clk = 0, rst = 1;
  logic [14:0] freq_val = '0;
  logic [7:0]  dur_val = '0;
  logic freq_wr = 0, dur_wr = 0, square_mode = 0, fin_zero = 0, f2f_mode = 0;
  logic signed [SAMP_W-1:0] sample;
  logic step_stb, busy;

  int vectors = 0, miscompares = 0;
  int exp_q[$];
  string cur_req = "R1";
  bit finished = 0;

  always #4 clk = ~clk;

  tone_burst_seq #(.REF_CLK(REF_CLK), .SAMP_W(SAMP_W)) i_tone_burst_seq (
    .clk(clk), .rst(rst), .freq_val(freq_val), .freq_wr(freq_wr),
    .dur_val(dur_val), .dur_wr(dur_wr), .square_mode(square_mode),
    .fin_zero(fin_zero), .f2f_mode(f2f_mode),
    .sample(sample), .step_stb(step_stb), .busy(busy)
  );

  function automatic int wave(int idx, bit sq);
    real x;
    if (sq) return (idx < 64) ? AMP : -AMP;
    x = AMP * $sin(2.0 * 3.141592653589793 * idx / 128.0);
    return (x >= 0.0) ? $rtoi($floor(x + 0.5)) : -$rtoi($floor(-x + 0.5));
  endfunction

  task automatic check(string req, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // driver side of the scoreboard: expected samples of n steps
  task automatic push_burst(int n, int start_idx, bit sq, bit ends);
    for (int k = 1; k <= n; k++)
      exp_q.push_back((k == n && ends) ? 0 : wave((start_idx + k) % 128, sq));
  endtask

  // monitor: pops one expected sample on every step strobe
  always @(negedge clk) begin
    if (!rst && step_stb) begin
      if (exp_q.size() == 0) check({cur_req, " unexpected step"}, 1, 0);
      else check(cur_req, int'(sample), exp_q.pop_front());
    end
  end

  task automatic wr_freq(int f);
    @(negedge clk); freq_val = 15'(f); freq_wr = 1;
    @(negedge clk); freq_wr = 0;
  endtask

  task automatic wr_dur(int d);
    @(negedge clk); dur_val = 8'(d); dur_wr = 1;
    @(negedge clk); dur_wr = 0;
  endtask

  task automatic drain(string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (40) @(negedge clk);
    check({req, " steps left"}, exp_q.size(), 0);
    check({req, " idle sample"}, int'(sample), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R10 reset sample", int'(sample), 0);
    check("R10 reset busy", int'(busy), 0);
    check("R10 reset step", int'(step_stb), 0);

    // R4: frequency alone starts nothing
    cur_req = "R4";
    wr_freq(10);
    repeat (200) @(negedge clk);
    check("R4 no start", int'(sample), 0);

    // R1/R2/R7: sine F=10, one unit = exactly one cycle, whole-cycle end
    cur_req = "R2";
    push_burst(128, 0, 0, 1);
    wr_dur(1);
    drain("R2");

    // R8: after the end, frequency write alone is silent
    cur_req = "R8";
    wr_freq(10);
    repeat (600) @(negedge clk);
    check("R8 no restart", exp_q.size(), 0);
    // R4: duration write restarts at the held frequency
    cur_req = "R4";
    push_burst(128, 0, 0, 1);
    wr_dur(1);
    drain("R4");

    // R6: F=4, time ends at index 51; zero-crossing mode stops at 64
    cur_req = "R6";
    fin_zero = 1;
    wr_freq(4);
    push_burst(64, 0, 0, 1);
    wr_dur(1);
    drain("R6 zero");
    fin_zero = 0;
    push_burst(128, 0, 0, 1);
    wr_dur(1);
    drain("R6 full");

    // R3: square wave
    cur_req = "R3";
    square_mode = 1;
    wr_freq(10);
    push_burst(128, 0, 1, 1);
    wr_dur(1);
    drain("R3");
    square_mode = 0;

    // R5: queue F=20 during a burst; duration carries, phase continues
    cur_req = "R5";
    push_burst(128, 0, 0, 0);
    push_burst(256, 0, 0, 1);
    wr_dur(1);
    repeat (100) @(negedge clk);
    wr_freq(20);
    check("R5 busy set", int'(busy), 1);
    repeat (500) @(negedge clk);
    check("R5 busy cleared", int'(busy), 0);
    drain("R5");

    // R7: dur 0 mid-burst drops the queue and ends at the next cycle end
    cur_req = "R7";
    wr_freq(4);
    push_burst(128, 0, 0, 1);
    wr_dur(5);
    repeat (100) @(negedge clk);
    wr_freq(10);
    check("R7 queued", int'(busy), 1);
    wr_dur(0);
    check("R7 queue dropped", int'(busy), 0);
    drain("R7");

    // R9: f2f, two units = one cycle at F plus two at 2F = 384 steps
    cur_req = "R9";
    f2f_mode = 1;
    wr_freq(10);
    push_burst(384, 0, 0, 1);
    wr_dur(2);
    drain("R9");
    f2f_mode = 0;

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check("watchdog", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule